// File: doc/BRIEF.md
# Memory-Operand Add Sequencer

This block runs one accumulate-from-memory operation over several clock cycles. A start pulse hands it a base register value, a 16-bit offset, the current value of the destination register and that register's index. The block forms the effective address, reads one full word from a single-port memory, adds the word to the destination value, and then returns a register write-back together with a one-cycle completion pulse.

Each of the three steps has its own state: address compute, memory read, then add. The memory returns its read data one clock after the address is presented. The block never writes memory. Instruction fetch, decode, the register file and the memory itself sit outside the block.

Top module: `memadd_seq`

## Requirements
- R1: The read address is the base value plus the 16-bit offset sign-extended to 32 bits, modulo 2^32. It appears on the memory address output only during the read cycle, which is the second cycle after the start edge. In every other cycle the address output is parked at zero.
- R2: The memory write enable is always low. The size output is 3 (full word) during the read cycle and 0 otherwise.
- R3: The write-back data is the destination value plus the memory word, both taken as signed 32-bit integers. The sum wraps modulo 2^32 and no overflow is signalled.
- R4: The done output is high for exactly one cycle. It is high in the cycle that follows the fourth rising edge, counting the edge that samples start as the first.
- R5: When the destination index is 0, the write-back strobe stays low, but done is still raised.
- R6: A start pulse while the block is busy is ignored. The operation in flight keeps its operands, address and timing.
- R7: During and after reset the block is idle: busy, done and the write-back strobe are low, and the address output is zero.
- R8: When the write-back strobe is high, the write-back index equals the destination index that was given at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed address offset |
| acc_i | input | 32 | Current destination register value |
| dst_i | input | 5 | Destination register index |
| mem_rdata_i | input | 32 | Memory read data, valid one cycle after the address |
| mem_addr_o | output | 32 | Memory address |
| mem_we_o | output | 1 | Memory write enable (always low) |
| mem_size_o | output | 2 | Access size, 3 = word, 0 = no access |
| wb_en_o | output | 1 | Register write-back strobe |
| wb_idx_o | output | 5 | Write-back register index |
| wb_data_o | output | 32 | Write-back value |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Operation in progress |

## Verification
The hardest case to reach from the ports is a second start that arrives in the exact cycle the memory read is issued, with operands that differ from those in flight. The block must not latch the new operands or restart. The bench raises start with fresh random values during the read cycle of chosen operations. It then checks that the address, the sum and the timing of done all still follow the first request. Negative offsets, offset extremes and sums that wrap are driven as directed cases alongside the random ones.

// File: rtl/memadd_pkg.sv
package memadd_pkg;
    parameter int unsigned XLEN   = 32;
    parameter int unsigned IMM_W  = 16;
    parameter int unsigned IDX_W  = 5;
    parameter int unsigned SIZE_W = 2;

    localparam logic [SIZE_W-1:0] SIZE_WORD = SIZE_W'(3);
    localparam logic [SIZE_W-1:0] SIZE_NONE = SIZE_W'(0);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_READ = 2'd2,
        ST_ADD  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/memadd_agu.sv
module memadd_agu #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IMM_W = 16
) (
    input  logic [XLEN-1:0]  base_i,
    input  logic [IMM_W-1:0] off_i,
    output logic [XLEN-1:0]  ea_o
);
    localparam int unsigned EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] off_ext;

    always_comb begin
        off_ext = {{EXT_W{off_i[IMM_W-1]}}, off_i};
        ea_o    = base_i + off_ext;
    end
endmodule

// File: rtl/memadd_acc.sv
module memadd_acc #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] reg_val_i,
    input  logic [XLEN-1:0] mem_val_i,
    output logic [XLEN-1:0] sum_o
);
    always_comb begin
        sum_o = reg_val_i + mem_val_i;
    end
endmodule

// File: rtl/memadd_seq.sv
module memadd_seq
    import memadd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [XLEN-1:0]     base_i,
    input  logic [IMM_W-1:0]    offset_i,
    input  logic [XLEN-1:0]     acc_i,
    input  logic [IDX_W-1:0]    dst_i,
    input  logic [XLEN-1:0]     mem_rdata_i,
    output logic [XLEN-1:0]     mem_addr_o,
    output logic                mem_we_o,
    output logic [SIZE_W-1:0]   mem_size_o,
    output logic                wb_en_o,
    output logic [IDX_W-1:0]    wb_idx_o,
    output logic [XLEN-1:0]     wb_data_o,
    output logic                done_o,
    output logic                busy_o
);
    typedef struct packed {
        seq_state_e        st;
        logic [XLEN-1:0]   base;
        logic [IMM_W-1:0]  off;
        logic [XLEN-1:0]   acc;
        logic [IDX_W-1:0]  dst;
        logic [XLEN-1:0]   ea;
        logic [XLEN-1:0]   wb_data;
        logic              wb_en;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [XLEN-1:0] ea_calc;
    logic [XLEN-1:0] sum_calc;

    memadd_agu #(.XLEN(XLEN), .IMM_W(IMM_W)) u_agu (
        .base_i (r_q.base),
        .off_i  (r_q.off),
        .ea_o   (ea_calc)
    );

    memadd_acc #(.XLEN(XLEN)) u_acc (
        .reg_val_i (r_q.acc),
        .mem_val_i (mem_rdata_i),
        .sum_o     (sum_calc)
    );

    always_comb begin
        r_d       = r_q;
        r_d.wb_en = 1'b0;
        r_d.done  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.base = base_i;
                    r_d.off  = offset_i;
                    r_d.acc  = acc_i;
                    r_d.dst  = dst_i;
                    r_d.st   = ST_ADDR;
                end
            end
            ST_ADDR: begin
                r_d.ea = ea_calc;
                r_d.st = ST_READ;
            end
            ST_READ: begin
                r_d.st = ST_ADD;
            end
            ST_ADD: begin
                r_d.wb_data = sum_calc;
                r_d.wb_en   = (r_q.dst != '0);
                r_d.done    = 1'b1;
                r_d.st      = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_we_o   = 1'b0;
        mem_addr_o = (r_q.st == ST_READ) ? r_q.ea : '0;
        mem_size_o = (r_q.st == ST_READ) ? SIZE_WORD : SIZE_NONE;
        wb_en_o    = r_q.wb_en;
        wb_idx_o   = r_q.dst;
        wb_data_o  = r_q.wb_data;
        done_o     = r_q.done;
        busy_o     = (r_q.st != ST_IDLE);
    end
endmodule

// File: rtl/memadd_seq_chk.sv
module memadd_seq_chk
    import memadd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic [XLEN-1:0]   mem_addr_o,
    input logic              mem_we_o,
    input logic [SIZE_W-1:0] mem_size_o,
    input logic              wb_en_o,
    input logic [IDX_W-1:0]  wb_idx_o,
    input logic              done_o
);
    assert_addr_parked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_size_o == SIZE_NONE) |-> (mem_addr_o == '0));

    assert_we_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_o);

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_read_to_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_size_o != SIZE_NONE) |=> (!done_o && busy_o && mem_size_o == SIZE_NONE) ##1 done_o);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_no_wb_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (done_o && wb_idx_o != '0));
endmodule

bind memadd_seq memadd_seq_chk u_memadd_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .mem_addr_o (mem_addr_o),
    .mem_we_o   (mem_we_o),
    .mem_size_o (mem_size_o),
    .wb_en_o    (wb_en_o),
    .wb_idx_o   (wb_idx_o),
    .done_o     (done_o)
);

// File: tb/tb_memadd_seq.sv
`timescale 1ns/1ps
module tb_memadd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] offset_i = '0;
    logic [31:0] acc_i = '0;
    logic [4:0]  dst_i = '0;
    logic [31:0] mem_rdata_i = '0;
    logic [31:0] mem_addr_o;
    logic        mem_we_o;
    logic [1:0]  mem_size_o;
    logic        wb_en_o;
    logic [4:0]  wb_idx_o;
    logic [31:0] wb_data_o;
    logic        done_o;
    logic        busy_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    memadd_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .offset_i(offset_i), .acc_i(acc_i), .dst_i(dst_i),
        .mem_rdata_i(mem_rdata_i), .mem_addr_o(mem_addr_o),
        .mem_we_o(mem_we_o), .mem_size_o(mem_size_o), .wb_en_o(wb_en_o),
        .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o), .done_o(done_o),
        .busy_o(busy_o)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'hA5C3_0F17;
    endfunction

    function automatic logic [31:0] exp_ea(input logic [31:0] b, input logic [15:0] o);
        return b + {{16{o[15]}}, o};
    endfunction

    // synchronous memory model: data one cycle after address
    always @(posedge clk) mem_rdata_i <= mem_word(mem_addr_o);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] b, input logic [15:0] o,
                          input logic [31:0] a, input logic [4:0] d, input bit intrude);
        logic [31:0] ea;
        logic [31:0] sum;
        ea  = exp_ea(b, o);
        sum = a + mem_word(ea);
        @(negedge clk);
        base_i = b; offset_i = o; acc_i = a; dst_i = d; start_i = 1'b1;
        @(posedge clk);              // edge 1: start sampled
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R6 busy after start", 32'(busy_o), 32'd1);
        check(mem_addr_o == 32'd0, "R1 parked in address cycle", mem_addr_o, 32'd0);
        @(posedge clk);              // edge 2: read cycle begins
        @(negedge clk);
        check(mem_addr_o == ea, "R1 effective address", mem_addr_o, ea);
        check(mem_size_o == 2'd3 && !mem_we_o, "R2 word read", {29'd0, mem_we_o, mem_size_o}, 32'd3);
        if (intrude) begin
            start_i = 1'b1;
            base_i = $urandom; offset_i = 16'($urandom); acc_i = $urandom; dst_i = 5'($urandom);
        end
        @(posedge clk);              // edge 3: add cycle
        @(negedge clk);
        start_i = 1'b0;
        check(mem_addr_o == 32'd0 && mem_size_o == 2'd0, "R2 no access in add cycle", mem_addr_o, 32'd0);
        check(!done_o, "R4 no early done", 32'(done_o), 32'd0);
        @(posedge clk);              // edge 4: results registered
        @(negedge clk);
        check(done_o, "R4 done after fourth edge", 32'(done_o), 32'd1);
        check(wb_en_o == (d != 5'd0), "R5 write-back strobe", 32'(wb_en_o), 32'(d != 5'd0));
        if (d != 5'd0) begin
            check(wb_idx_o == d, "R8 write-back index", 32'(wb_idx_o), 32'(d));
            check(wb_data_o == sum, intrude ? "R6 sum kept after busy start" : "R3 wrapped sum", wb_data_o, sum);
        end
        check(!busy_o, "R6 idle at done", 32'(busy_o), 32'd0);
        @(posedge clk);
        @(negedge clk);
        check(!done_o && !wb_en_o, "R4 single-cycle done", {30'd0, done_o, wb_en_o}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20241));
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !wb_en_o && mem_addr_o == 0, "R7 reset state",
              {28'd0, busy_o, done_o, wb_en_o, |mem_addr_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && mem_addr_o == 0, "R7 idle after reset", 32'(busy_o), 32'd0);
        // directed corner cases
        run_op(32'h0000_1000, 16'h0004, 32'd5, 5'd3, 1'b0);          // R1 positive offset
        run_op(32'h0000_1000, 16'h8000, 32'd7, 5'd9, 1'b0);          // R1 most negative
        run_op(32'h0000_0010, 16'hFFFC, 32'd1, 5'd31, 1'b0);         // R1 -4
        run_op(32'hFFFF_FFF0, 16'h7FFF, 32'hFFFF_FFFF, 5'd1, 1'b0);  // R1 address wrap, R3 sum wrap
        run_op(32'h8000_0000, 16'h0000, 32'h7FFF_FFFF, 5'd0, 1'b0);  // R5 index 0
        run_op(32'h0000_2000, 16'h0020, 32'h8000_0000, 5'd17, 1'b1); // R6 start during read
        for (int i = 0; i < 60; i++) begin
            run_op($urandom, 16'($urandom), $urandom, 5'($urandom), ($urandom % 4) == 0);
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule